// File: doc/BRIEF.md
# Bit-serial NLFSR keystream generator

This core is a bit-serial keystream generator for an 80-bit key and 64-bit IV stream cipher. It holds two 80-bit shift registers. One is linear (called L below) and one is nonlinear (called N below). A nonlinear filter reads both registers and gives one keystream bit on every clock. Both registers shift toward bit 0, and each one computes a new value for its top bit.

A one-cycle `start` pulse loads the key and the IV and begins a warm-up of 160 clocks. During warm-up the filter output is XORed into the new top bit of both registers, and the output is held invalid. After warm-up the feedback from the filter is removed. From then on the core gives one valid keystream bit per clock until the next `start`. A `start` at any time discards the current run, reloads the state and begins warm-up again.

Top module: `nlfsr_stream_core`

## Requirements
- R1: While reset is held, and after its release until the first `start`, `ks_valid` is 0 and `ks_bit` is 0.
- R2: On a clock with `start` high, N loads `key` (`key[i]` into N bit i). L bits 0 to 63 load `iv[i]`, and L bits 64 to 79 load 1.
- R3: After the load clock there are exactly 160 warm-up clocks. During them `ks_valid` is 0 and `ks_bit` is 0. `ks_valid` is 1 in the cycle after the 160th warm-up clock.
- R4: On each clock both registers shift toward bit 0. The new L bit 79 is s62^s51^s38^s23^s13^s0. The new N bit 79 is s0^b0^b62^b60^b52^b45^b37^b33^b28^b21^b14^b9 XOR the products b63b60, b37b33, b15b9, b60b52b45, b33b28b21, b63b45b28b9, b60b52b37b33, b63b60b21b15, b63b60b52b45b37, b33b28b21b15b9 and b52b45b37b33b28b21. Here s is L and b is N.
- R5: The filter is h = s25^b63^s3s4^s46s4^s4b63^s3s25s46^s3s46s4^s3s46b63^s25s46b63^s46s4b63. The keystream bit is z = b1^b2^b4^b10^b31^b43^b56^h. During warm-up, z is XORed into both new top bits. After warm-up it is not fed back.
- R6: Once `ks_valid` is 1, it stays 1 and one new keystream bit appears on every clock until the next `start`.
- R7: A `start` during warm-up abandons that warm-up. The core reloads and runs a full new warm-up of 160 clocks.
- R8: A `start` while keystream is being produced drops `ks_valid` in the next cycle and begins a full new warm-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load key and IV and begin warm-up |
| key | input | 80 | Key, sampled when start is high |
| iv | input | 64 | IV, sampled when start is high |
| ks_bit | output | 1 | Keystream bit, 0 when not valid |
| ks_valid | output | 1 | Keystream bit is valid |

## Verification
The assertions assume that `start` is synchronous to `clk`. They also assume that `key` and `iv` matter only in the clock where `start` is high, since the core samples them nowhere else. The bench drives `start` and the load data at the falling edge and holds them for exactly one cycle, so each pulse gives one load. It checks every keystream bit against a separate model of the equations, for several keys and IVs. It also aborts runs during warm-up and during keystream output.

// File: rtl/nlfsr_stream_core.sv
module nlfsr_stream_core #(
  parameter int LEN         = 80,
  parameter int IVW         = 64,
  parameter int INIT_CYCLES = 160,
  parameter int CW          = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [LEN-1:0] key,
  input  logic [IVW-1:0] iv,
  output logic           ks_bit,
  output logic           ks_valid
);
  localparam int FILL = LEN - IVW;
  localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

  logic [LEN-1:0] s, b;
  logic [CW-1:0]  cnt;
  logic           warm, run;
  logic           h, z, lfb, nfb, fb_z;

  assign h = s[25] ^ b[63] ^ (s[3] & s[4]) ^ (s[46] & s[4]) ^ (s[4] & b[63])
           ^ (s[3] & s[25] & s[46]) ^ (s[3] & s[46] & s[4]) ^ (s[3] & s[46] & b[63])
           ^ (s[25] & s[46] & b[63]) ^ (s[46] & s[4] & b[63]);

  assign z = b[1] ^ b[2] ^ b[4] ^ b[10] ^ b[31] ^ b[43] ^ b[56] ^ h;

  assign lfb = s[62] ^ s[51] ^ s[38] ^ s[23] ^ s[13] ^ s[0];

  assign nfb = s[0] ^ b[0] ^ b[62] ^ b[60] ^ b[52] ^ b[45] ^ b[37] ^ b[33]
             ^ b[28] ^ b[21] ^ b[14] ^ b[9]
             ^ (b[63] & b[60]) ^ (b[37] & b[33]) ^ (b[15] & b[9])
             ^ (b[60] & b[52] & b[45]) ^ (b[33] & b[28] & b[21])
             ^ (b[63] & b[45] & b[28] & b[9])
             ^ (b[60] & b[52] & b[37] & b[33])
             ^ (b[63] & b[60] & b[21] & b[15])
             ^ (b[63] & b[60] & b[52] & b[45] & b[37])
             ^ (b[33] & b[28] & b[21] & b[15] & b[9])
             ^ (b[52] & b[45] & b[37] & b[33] & b[28] & b[21]);

  assign fb_z = warm & z;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s    <= '0;
      b    <= '0;
      cnt  <= '0;
      warm <= 1'b0;
      run  <= 1'b0;
    end else if (start) begin
      b    <= key;
      s    <= {{FILL{1'b1}}, iv};
      cnt  <= '0;
      warm <= 1'b1;
      run  <= 1'b0;
    end else if (warm || run) begin
      s <= {lfb ^ fb_z, s[LEN-1:1]};
      b <= {nfb ^ fb_z, b[LEN-1:1]};
      if (warm) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          warm <= 1'b0;
          run  <= 1'b1;
        end
      end
    end
  end

  assign ks_valid = run;
  assign ks_bit   = run & z;

  p_quiet_warm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (!ks_valid && !ks_bit));

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (cnt <= LAST));

  p_warm_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && cnt == LAST && !start) |=> ks_valid);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (s[LEN-1:IVW] == {FILL{1'b1}} && cnt == '0 && warm));

  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !start) |=> (b[LEN-2:0] == $past(b[LEN-1:1]) && s[LEN-2:0] == $past(s[LEN-1:1])));

  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !start) |=> ks_valid);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ks_valid);

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(warm && run));

  always_comb begin
    if (!ks_valid) assert (ks_bit == 1'b0);
  end
endmodule

// File: tb/tb_nlfsr_stream_core.sv
module tb_nlfsr_stream_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [79:0] key = '0;
  logic [63:0] iv = '0;
  logic        ks_bit, ks_valid;

  int checks = 0;
  int errors = 0;
  logic [79:0] ms, mb;

  always #2 clk = ~clk;

  nlfsr_stream_core dut (.clk(clk), .rst_n(rst_n), .start(start), .key(key),
                         .iv(iv), .ks_bit(ks_bit), .ks_valid(ks_valid));

  function automatic logic fz(input logic [79:0] l, input logic [79:0] n);
    logic hv;
    hv = l[25] ^ n[63] ^ (l[3] & l[4]) ^ (l[46] & l[4]) ^ (l[4] & n[63])
       ^ (l[3] & l[25] & l[46]) ^ (l[3] & l[46] & l[4]) ^ (l[3] & l[46] & n[63])
       ^ (l[25] & l[46] & n[63]) ^ (l[46] & l[4] & n[63]);
    return n[1] ^ n[2] ^ n[4] ^ n[10] ^ n[31] ^ n[43] ^ n[56] ^ hv;
  endfunction

  task automatic model_step(input logic fold);
    logic zz, nl, nn;
    zz = fold & fz(ms, mb);
    nl = ms[62] ^ ms[51] ^ ms[38] ^ ms[23] ^ ms[13] ^ ms[0];
    nn = ms[0] ^ mb[0] ^ mb[62] ^ mb[60] ^ mb[52] ^ mb[45] ^ mb[37] ^ mb[33]
       ^ mb[28] ^ mb[21] ^ mb[14] ^ mb[9]
       ^ (mb[63] & mb[60]) ^ (mb[37] & mb[33]) ^ (mb[15] & mb[9])
       ^ (mb[60] & mb[52] & mb[45]) ^ (mb[33] & mb[28] & mb[21])
       ^ (mb[63] & mb[45] & mb[28] & mb[9])
       ^ (mb[60] & mb[52] & mb[37] & mb[33])
       ^ (mb[63] & mb[60] & mb[21] & mb[15])
       ^ (mb[63] & mb[60] & mb[52] & mb[45] & mb[37])
       ^ (mb[33] & mb[28] & mb[21] & mb[15] & mb[9])
       ^ (mb[52] & mb[45] & mb[37] & mb[33] & mb[28] & mb[21]);
    ms = {nl ^ zz, ms[79:1]};
    mb = {nn ^ zz, mb[79:1]};
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_start(input logic [79:0] k, input logic [63:0] v);
    key = k; iv = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mb = k;
    ms = {16'hFFFF, v};
  endtask

  task automatic warm_up(input string req);
    int bad = 0;
    for (int i = 0; i < 160; i++) begin
      if (ks_valid !== 1'b0 || ks_bit !== 1'b0) bad++;
      @(negedge clk);
      model_step(1'b1);
    end
    check(req, bad == 0, 1'b1);
    check(req, ks_valid, 1'b1);
  endtask

  task automatic stream(input string req, input int nbits);
    for (int j = 0; j < nbits; j++) begin
      check(req, ks_valid, 1'b1);
      check(req, ks_bit, fz(ms, mb));
      @(negedge clk);
      model_step(1'b0);
    end
  endtask

  task automatic t_reset_r1;
    check("R1 valid in reset", ks_valid, 1'b0);
    check("R1 bit in reset", ks_bit, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 valid idle", ks_valid, 1'b0);
    check("R1 bit idle", ks_bit, 1'b0);
  endtask

  task automatic t_run_r2_r4_r5(input logic [79:0] k, input logic [63:0] v);
    pulse_start(k, v);
    warm_up("R3 warm-up");
    stream("R2/R4/R5 keystream", 64);
  endtask

  task automatic t_long_r6;
    pulse_start(80'h0123_4567_89AB_CDEF_1357, 64'hFEDC_BA98_7654_3210);
    warm_up("R3 warm-up");
    stream("R6 continuous", 400);
  endtask

  task automatic t_abort_warm_r7;
    pulse_start(80'hAAAA_5555_AAAA_5555_AAAA, 64'h1);
    repeat (70) @(negedge clk);
    check("R7 no output mid warm-up", ks_valid, 1'b0);
    pulse_start(80'h0F0F_0F0F_0F0F_0F0F_0F0F, 64'h8000_0000_0000_0001);
    warm_up("R7 full warm-up after abort");
    stream("R7 keystream after abort", 32);
  endtask

  task automatic t_restart_run_r8;
    pulse_start(80'h1, 64'h0);
    warm_up("R3 warm-up");
    stream("R8 first run", 20);
    pulse_start(80'hFFFF_FFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R8 valid drops", ks_valid, 1'b0);
    warm_up("R8 full warm-up after restart");
    stream("R8 keystream after restart", 32);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    t_run_r2_r4_r5(80'h0, 64'h0);
    t_run_r2_r4_r5(80'h8000_0000_0000_0000_0001, 64'h0000_0000_0000_0080);
    t_run_r2_r4_r5(80'hDEAD_BEEF_CAFE_F00D_1234, 64'h0BAD_5EED_C0DE_7777);
    t_long_r6();
    t_abort_warm_r7();
    t_restart_run_r8();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule